// File: doc/BRIEF.md
# Multiprocessor Shared-Bus Arbiter

This block decides which master drives a shared external bus. Up to six processor agents and one host agent compete for it. Each agent raises a request line and receives a grant line. A run-time mode input chooses the processor priority scheme. In fixed order, processor 1 always beats processor 6. In rotating order, the processor granted most recently falls to the back of the queue.

The host ranks above every processor. When no lock is held, a host request takes the bus from a processor owner. A master keeps the bus, with no lost cycle, for as long as it keeps requesting and nothing with a stronger claim shows up.

Handing the bus directly from one master to another always inserts exactly one cycle in which no grant is driven. The winner is chosen again at the end of that cycle. A lock input freezes ownership so that a semaphore read-modify-write cannot be split. The block also reports the ID of the current owner and a bus-busy flag. All outputs come straight from flops.

Top module: `mp_bus_arb`

## Requirements
- R1: After reset no grant is asserted, `owner_id` is 0 and `bus_busy` is 0. The rotation starts with processor 1 as the highest-priority processor, so in rotating mode with processors 1 and 6 both requesting from reset, processor 1 wins.
- R2: When no master owns the bus and no changeover is in progress, the highest-priority requester is granted on the next clock edge, without an idle cycle.
- R3: In fixed mode (`rot_mode`=0), processor ID 1 has the highest priority and ID 6 the lowest. A request from a processor with a lower ID than the current owner preempts the owner through a changeover. A request from a processor with a higher ID does not.
- R4: In rotating mode (`rot_mode`=1), the processor granted last becomes the lowest priority, and the search starts at the next ID and wraps from 6 to 1. A requesting processor owner is never preempted by another processor.
- R5: Moving ownership from one master to a different master inserts exactly one cycle in which all grants are 0, `owner_id` is 0 and `bus_busy` is 0. A grant never changes directly from one master to another.
- R6: The host (`owner_id` 7, `host_gnt`) ranks above all processors. It wins from idle, and it preempts a processor owner through a changeover when `lock` is 0.
- R7: While `lock` is 1 and a master owns the bus, ownership does not change. This holds even if the owner drops its request, and even if the host or higher-priority processors are requesting.
- R8: A master that keeps requesting, with no preempting request present, keeps its grant on consecutive cycles without any changeover cycle.
- R9: When the owner stops requesting and no other agent requests (with `lock` 0), the bus becomes free on the next edge: no grant, `owner_id` 0, `bus_busy` 0.
- R10: At most one grant is asserted at a time. `gnt[i]` corresponds to `owner_id` i+1, and `bus_busy` is 1 exactly when a grant is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NPROC | Processor requests; bit i is processor ID i+1 |
| host_req | input | 1 | Host request |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| lock | input | 1 | Hold ownership with the current master |
| gnt | output | NPROC | Processor grants, one-hot or zero |
| host_gnt | output | 1 | Host grant |
| owner_id | output | IDW | 0 = none, 1..NPROC = processor, NPROC+1 = host |
| bus_busy | output | 1 | A master currently holds the bus |

## Verification
Single requests from idle show that the grant arrives without a gap. A lower-ID request arriving while a higher-ID processor owns the bus separates fixed from rotating mode: it preempts in one mode and not in the other. Rotating sequences in which the owner drops its request reveal whether the search starts after the last owner and wraps correctly, and a pattern with processors 1 and 6 both requesting exposes the pointer's reset value. Host and higher-priority requests presented under lock, including a case where the owner drops its own request, show that lock overrides every other input. After lock is released, the host taking the bus confirms the single changeover cycle.

// File: rtl/mp_bus_arb_pkg.sv
package mp_bus_arb_pkg;
  // Owner ID reserved for "no master"
  localparam int OWNER_NONE = 0;

  function automatic int host_id(input int nproc);
    return nproc + 1;
  endfunction
endpackage

// File: rtl/mp_bus_arb_pick.sv
// Combinational processor picker: fixed order from index 0, or rotating
// order starting just after the last granted index.
module mp_bus_arb_pick #(
  parameter int NPROC = 6,
  parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NPROC-1:0] req,
  input  logic [PW-1:0]    last,
  input  logic             rot_mode,
  output logic             valid,
  output logic [PW-1:0]    idx
);
  always_comb begin
    int start;
    valid = 1'b0;
    idx   = '0;
    start = rot_mode ? (int'(last) + 1) : 0;
    if (start >= NPROC) start = start - NPROC;
    for (int k = 0; k < NPROC; k++) begin
      int i;
      i = start + k;
      if (i >= NPROC) i = i - NPROC;
      if (!valid && req[i]) begin
        valid = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/mp_bus_arb_ptr.sv
// Rotation pointer: index of the processor granted most recently.
module mp_bus_arb_ptr #(
  parameter int NPROC = 6,
  parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_idx,
  output logic [PW-1:0] last
);
  always_ff @(posedge clk) begin
    if (rst)       last <= PW'(NPROC - 1);  // so index 0 is searched first
    else if (load) last <= load_idx;
  end
endmodule

// File: rtl/mp_bus_arb.sv
module mp_bus_arb
  import mp_bus_arb_pkg::*;
#(
  parameter int NPROC = 6,
  localparam int IDW  = $clog2(NPROC + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPROC-1:0] req,
  input  logic             host_req,
  input  logic             rot_mode,
  input  logic             lock,
  output logic [NPROC-1:0] gnt,
  output logic             host_gnt,
  output logic [IDW-1:0]   owner_id,
  output logic             bus_busy
);
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam logic [IDW-1:0] HOST = IDW'(host_id(NPROC));
  localparam logic [IDW-1:0] NONE = IDW'(OWNER_NONE);

  logic [IDW-1:0]   owner_q, owner_n;
  logic             gap_q, gap_n;
  logic [NPROC-1:0] gnt_n;
  logic [PW-1:0]    last, pidx, ld_idx;
  logic             pvalid, ld, own_req;

  mp_bus_arb_pick #(.NPROC(NPROC), .PW(PW)) u_pick (
    .req(req), .last(last), .rot_mode(rot_mode), .valid(pvalid), .idx(pidx)
  );

  mp_bus_arb_ptr #(.NPROC(NPROC), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .load(ld), .load_idx(ld_idx), .last(last)
  );

  always_comb begin
    logic [IDW-1:0] fresh, want, pid;
    pid   = IDW'(pidx) + IDW'(1);
    fresh = host_req ? HOST : (pvalid ? pid : NONE);
    own_req = 1'b0;
    for (int i = 0; i < NPROC; i++)
      if (owner_q == IDW'(i + 1)) own_req = req[i];
    if (owner_q == HOST) own_req = host_req;
    owner_n = owner_q;
    gap_n   = 1'b0;
    want    = owner_q;
    if (gap_q || owner_q == NONE) begin
      owner_n = fresh;
    end else if (!lock) begin
      if (host_req)
        want = HOST;
      else if (own_req)
        want = (!rot_mode && pvalid && pid < owner_q) ? pid : owner_q;
      else
        want = fresh;
      if (want == NONE) begin
        owner_n = NONE;
      end else if (want != owner_q) begin
        owner_n = NONE;
        gap_n   = 1'b1;
      end
    end
    ld     = 1'b0;
    ld_idx = '0;
    for (int i = 0; i < NPROC; i++)
      if (owner_n == IDW'(i + 1) && owner_n != owner_q) begin
        ld     = 1'b1;
        ld_idx = PW'(i);
      end
  end

  for (genvar g = 0; g < NPROC; g++) begin : g_dec
    assign gnt_n[g] = (owner_n == IDW'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= NONE;
      gap_q    <= 1'b0;
      gnt      <= '0;
      host_gnt <= 1'b0;
      bus_busy <= 1'b0;
    end else begin
      owner_q  <= owner_n;
      gap_q    <= gap_n;
      gnt      <= gnt_n;
      host_gnt <= (owner_n == HOST);
      bus_busy <= (owner_n != NONE);
    end
  end

  assign owner_id = owner_q;

  // R10: grants mutually exclusive
  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({host_gnt, gnt}));

  // R5: no direct hand-over between two masters
  assert_changeover_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (|{host_gnt, gnt}) |=> ({host_gnt, gnt} == $past({host_gnt, gnt}) || {host_gnt, gnt} == '0));

  // R7: lock freezes the owner
  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (lock && bus_busy) |=> $stable({host_gnt, gnt}));

  // R9: owner drops and nobody requests -> bus free
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && !lock && !host_req && req == '0) |=> !bus_busy);

  // R4: rotating mode, requesting processor owner is not preempted by processors
  assert_rot_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (rot_mode && !lock && !host_req && (req & gnt) != '0) |=> $stable(gnt));
endmodule

// File: tb/mp_bus_arb_test.sv
`timescale 1ns/1ps
module mp_bus_arb_test;
  localparam int NPROC = 6;
  logic clk = 1'b0;
  logic rst;
  logic [NPROC-1:0] req;
  logic host_req, rot_mode, lock;
  logic [NPROC-1:0] gnt;
  logic host_gnt, bus_busy;
  logic [2:0] owner_id;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mp_bus_arb #(.NPROC(NPROC)) uut (
    .clk(clk), .rst(rst), .req(req), .host_req(host_req), .rot_mode(rot_mode),
    .lock(lock), .gnt(gnt), .host_gnt(host_gnt), .owner_id(owner_id), .bus_busy(bus_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Check all outputs against an expected owner ID (0 none, 1..6 processor, 7 host)
  task automatic expect_owner(input string tag, input int id);
    int eg;
    eg = (id >= 1 && id <= NPROC) ? (1 << (id - 1)) : 0;
    chk({tag, " owner_id"}, int'(owner_id), id);
    chk({tag, " gnt"}, int'(gnt), eg);
    chk({tag, " host_gnt"}, int'(host_gnt), (id == NPROC + 1) ? 1 : 0);
    chk({tag, " bus_busy"}, int'(bus_busy), (id != 0) ? 1 : 0);
  endtask

  // Apply inputs at a falling edge; result visible at the next falling edge
  task automatic step(input logic [NPROC-1:0] r, input logic h, input logic m, input logic l);
    req = r; host_req = h; rot_mode = m; lock = l;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; host_req = 1'b0; rot_mode = 1'b0; lock = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_owner("R1 reset", 0);
    step(6'b100001, 0, 1, 0);
    expect_owner("R1 rotation starts at 1", 1);
  endtask

  task automatic t_fixed();
    do_reset();
    step(6'b000100, 0, 0, 0);
    expect_owner("R2 idle grant", 3);
    step(6'b000100, 0, 0, 0);
    expect_owner("R8 keep", 3);
    step(6'b100100, 0, 0, 0);
    expect_owner("R3 lower priority no preempt", 3);
    step(6'b000101, 0, 0, 0);
    expect_owner("R5 gap cycle", 0);
    step(6'b000101, 0, 0, 0);
    expect_owner("R3 higher priority wins", 1);
    step(6'b000000, 0, 0, 0);
    expect_owner("R9 release", 0);
    step(6'b111111, 0, 0, 0);
    expect_owner("R3 all request fixed", 1);
  endtask

  task automatic t_rotate();
    do_reset();
    step(6'b100001, 0, 1, 0);
    expect_owner("R2 rot idle grant", 1);
    step(6'b111111, 0, 1, 0);
    expect_owner("R4 rot owner not preempted", 1);
    step(6'b111110, 0, 1, 0);
    expect_owner("R5 rot gap", 0);
    step(6'b111110, 0, 1, 0);
    expect_owner("R4 rot next after 1", 2);
    step(6'b111101, 0, 1, 0);
    expect_owner("R5 rot gap 2", 0);
    step(6'b111101, 0, 1, 0);
    expect_owner("R4 rot next after 2", 3);
    step(6'b111101, 0, 1, 0);
    expect_owner("R4 rot keep with 1 requesting", 3);
    step(6'b000001, 0, 1, 0);
    expect_owner("R5 rot gap wrap", 0);
    step(6'b000001, 0, 1, 0);
    expect_owner("R4 rot wrap to 1", 1);
  endtask

  task automatic t_host();
    do_reset();
    step(6'b111111, 1, 0, 0);
    expect_owner("R6 host from idle", 7);
    step(6'b000000, 0, 0, 0);
    expect_owner("R9 host release", 0);
    step(6'b010000, 0, 0, 0);
    expect_owner("R2 grant 5", 5);
    step(6'b010000, 1, 0, 0);
    expect_owner("R5 host gap", 0);
    step(6'b010000, 1, 0, 0);
    expect_owner("R6 host preempts", 7);
  endtask

  task automatic t_lock();
    do_reset();
    step(6'b000100, 0, 0, 0);
    expect_owner("R7 setup", 3);
    step(6'b000101, 1, 0, 1);
    expect_owner("R7 lock vs host", 3);
    step(6'b000101, 1, 0, 1);
    expect_owner("R7 lock vs host 2", 3);
    step(6'b000000, 0, 0, 1);
    expect_owner("R7 lock owner dropped", 3);
    step(6'b000000, 1, 0, 0);
    expect_owner("R5 unlock gap", 0);
    step(6'b000000, 1, 0, 0);
    expect_owner("R6 host after unlock", 7);
  endtask

  initial begin
    rst = 1'b1; req = '0; host_req = 1'b0; rot_mode = 1'b0; lock = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_rotate();
    t_host();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule